// File: doc/BRIEF.md
# Broadcast Delivery Tracker

This block accepts messages from a single producer and hands every message to each of a fixed number of receivers. Incoming messages wait in a small first-in first-out queue. The oldest queued message is presented to all receivers through one shared data bus, and every receiver has its own valid and acknowledge pair.

Receivers take the message independently and in any cycle they like. The block remembers, in one flag per receiver, which receivers have already taken the current message. It stops presenting the message to those receivers. The message leaves the queue only in the cycle when the last outstanding receiver acknowledges it. The producer is held off by a full indication from the queue. The receiver count, the data width and the queue depth are all fixed when the design is elaborated.

Top module: `bcast_fanout`

## Requirements
- R1: After reset the queue is empty, every delivered flag is clear, `rx_valid` is all zero and `in_full` is low.
- R2: While the queue holds no message, every bit of `rx_valid` is 0, whatever `rx_ack` does.
- R3: While the queue holds a message, `rx_data` carries the oldest message, and `rx_valid[i]` is 1 exactly for the receivers that have not yet acknowledged it.
- R4: A clock edge on which `rx_valid[i]` and `rx_ack[i]` are both 1 marks receiver i as delivered. From the next cycle on, `rx_valid[i]` stays 0 for as long as that message remains the head.
- R5: In the cycle where the remaining receivers' acknowledgements complete the set, the head message is removed at that edge and all flags are cleared at the same edge. One cycle in which all receivers acknowledge together is enough.
- R6: If another message is queued behind a retiring head, it is presented to all receivers, with every `rx_valid` bit at 1, in the cycle right after the retiring edge.
- R7: `in_full` is 1 when DEPTH messages are stored. An `in_valid` pulse while `in_full` is 1 stores nothing.
- R8: Messages reach the receivers in the order in which they were accepted.
- R9: An `rx_ack[i]` given while `rx_valid[i]` is 0 has no effect on any flag or on the queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer offers `in_data` this cycle |
| in_data | input | DATA_W | Message from the producer |
| in_full | output | 1 | Queue full; an offer is not accepted |
| rx_valid | output | NUM_RX | Per-receiver offer of the head message |
| rx_ack | input | NUM_RX | Per-receiver acceptance of the offer |
| rx_data | output | DATA_W | Head message, shared by all receivers |

## Verification
Several acknowledgement patterns are applied. In one, receivers acknowledge one at a time in a scattered order; this separates per-receiver flag tracking from a design that retires early. In another, all receivers acknowledge in the same cycle; this exposes any lost cycle between two heads. Repeated and out-of-turn acknowledgements are sent to receivers whose valid is already low, to show that they are ignored. A run that fills the queue and pushes one extra message, then drains it, checks the full threshold, that the extra message is dropped, and that delivery order is kept.

// File: rtl/bcast_pkg.sv
package bcast_pkg;
   // Width of an index into a store of the given number of entries (min 1).
   function automatic int unsigned idx_w(input int unsigned entries);
      return (entries > 1) ? $clog2(entries) : 1;
   endfunction

   // Width of an occupancy counter able to hold 0..entries.
   function automatic int unsigned occ_w(input int unsigned entries);
      return $clog2(entries + 1);
   endfunction
endpackage

// File: rtl/bcast_fifo.sv
module bcast_fifo
   import bcast_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 4,
   localparam int unsigned PTR_W = idx_w(DEPTH),
   localparam int unsigned CNT_W = occ_w(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] rdata,
   output logic              empty,
   output logic              full,
   output logic [CNT_W-1:0]  count
);
   logic do_push, do_pop;
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;

   generate
      if (DEPTH == 1) begin : g_single
         logic              occ;
         logic [DATA_W-1:0] slot;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               occ <= 1'b0;
            end else if (do_push) begin
               occ <= 1'b1;
            end else if (do_pop) begin
               occ <= 1'b0;
            end
         end

         always_ff @(posedge clk) begin
            if (do_push) slot <= wdata;
         end

         assign rdata = slot;
         assign empty = ~occ;
         assign full  = occ;
         assign count = CNT_W'(occ);
      end else begin : g_ring
         logic [DATA_W-1:0] mem [DEPTH];
         logic [PTR_W-1:0]  wr_ptr, rd_ptr;
         logic [CNT_W-1:0]  cnt;

         function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
            return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
         endfunction

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wr_ptr <= '0;
               rd_ptr <= '0;
               cnt    <= '0;
            end else begin
               if (do_push) wr_ptr <= bump(wr_ptr);
               if (do_pop)  rd_ptr <= bump(rd_ptr);
               case ({do_push, do_pop})
                  2'b10:   cnt <= cnt + CNT_W'(1);
                  2'b01:   cnt <= cnt - CNT_W'(1);
                  default: cnt <= cnt;
               endcase
            end
         end

         always_ff @(posedge clk) begin
            if (do_push) mem[wr_ptr] <= wdata;
         end

         assign rdata = mem[rd_ptr];
         assign empty = (cnt == '0);
         assign full  = (cnt == CNT_W'(DEPTH));
         assign count = cnt;
      end
   endgenerate
endmodule

// File: rtl/bcast_flags.sv
module bcast_flags #(
   parameter int unsigned NUM_RX = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              head_ok,
   input  logic [NUM_RX-1:0] rx_ack,
   output logic [NUM_RX-1:0] rx_valid,
   output logic              retire,
   output logic [NUM_RX-1:0] flags
);
   logic [NUM_RX-1:0] taken;
   logic [NUM_RX-1:0] done_next;

   generate
      for (genvar i = 0; i < NUM_RX; i++) begin : g_rx
         assign rx_valid[i]  = head_ok & ~flags[i];
         assign taken[i]     = rx_valid[i] & rx_ack[i];
         assign done_next[i] = flags[i] | taken[i];
      end
   endgenerate

   assign retire = head_ok & (&done_next);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags <= '0;
      end else if (retire) begin
         flags <= '0;
      end else begin
         flags <= done_next;
      end
   end
endmodule

// File: rtl/bcast_fanout.sv
module bcast_fanout
   import bcast_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned NUM_RX = 4,
   localparam int unsigned CNT_W = occ_w(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_full,
   output logic [NUM_RX-1:0] rx_valid,
   input  logic [NUM_RX-1:0] rx_ack,
   output logic [DATA_W-1:0] rx_data
);
   generate
      if (NUM_RX < 1) begin : g_bad_rx
         $error("bcast_fanout: NUM_RX must be at least 1");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("bcast_fanout: DEPTH must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("bcast_fanout: DATA_W must be at least 1");
      end
   endgenerate

   logic              fifo_empty;
   logic              head_ok;
   logic              retire;
   logic [NUM_RX-1:0] flags;
   logic [CNT_W-1:0]  count;

   assign head_ok = ~fifo_empty;

   bcast_fifo #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (in_valid),
      .wdata (in_data),
      .pop   (retire),
      .rdata (rx_data),
      .empty (fifo_empty),
      .full  (in_full),
      .count (count)
   );

   bcast_flags #(
      .NUM_RX (NUM_RX)
   ) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .head_ok  (head_ok),
      .rx_ack   (rx_ack),
      .rx_valid (rx_valid),
      .retire   (retire),
      .flags    (flags)
   );
endmodule

// File: rtl/bcast_fanout_chk.sv
module bcast_fanout_chk #(
   parameter int unsigned NUM_RX = 4,
   parameter int unsigned CNT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_full,
   input logic [NUM_RX-1:0] rx_valid,
   input logic [NUM_RX-1:0] rx_ack,
   input logic              head_ok,
   input logic              retire,
   input logic [NUM_RX-1:0] flags,
   input logic [CNT_W-1:0]  count
);
   // R2
   no_offer_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !head_ok |-> (rx_valid == '0));

   // R5
   flags_clear_after_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retire |=> (flags == '0));

   // R7
   no_growth_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_full && in_valid) |=> (count <= $past(count)));

   generate
      for (genvar i = 0; i < NUM_RX; i++) begin : g_rx_chk
         // R4
         valid_drops_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_valid[i] && rx_ack[i] && !retire) |=> !rx_valid[i]);

         // R4
         flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !retire) |=> flags[i]);
      end
   endgenerate
endmodule

bind bcast_fanout bcast_fanout_chk #(
   .NUM_RX (NUM_RX),
   .CNT_W  (CNT_W)
) u_chk (.*);

// File: tb/tb_bcast_fanout.sv
module tb_bcast_fanout;
   localparam int DATA_W = 8;
   localparam int DEPTH  = 4;
   localparam int NUM_RX = 4;
   localparam logic [NUM_RX-1:0] ALL = '1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [DATA_W-1:0] in_data = '0;
   logic              in_full;
   logic [NUM_RX-1:0] rx_valid;
   logic [NUM_RX-1:0] rx_ack = '0;
   logic [DATA_W-1:0] rx_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bcast_fanout #(.DATA_W(DATA_W), .DEPTH(DEPTH), .NUM_RX(NUM_RX)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_full(in_full), .rx_valid(rx_valid), .rx_ack(rx_ack), .rx_data(rx_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push(input logic [DATA_W-1:0] d);
      in_valid = 1'b1;
      in_data  = d;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   task automatic ack(input logic [NUM_RX-1:0] a);
      rx_ack = a;
      @(posedge clk);
      #1;
      rx_ack = '0;
   endtask

   task automatic t_reset;
      chk("R1 rx_valid", 32'(rx_valid), 32'(0));
      chk("R1 in_full", 32'(in_full), 32'(0));
      ack(ALL); // R2: acks with nothing queued
      chk("R2 rx_valid empty", 32'(rx_valid), 32'(0));
   endtask

   task automatic t_staggered;
      push(8'hA1);
      chk("R3 all offered", 32'(rx_valid), 32'(ALL));
      chk("R3 head data", 32'(rx_data), 32'h A1);
      ack(4'b0001);
      chk("R4 rx0 dropped", 32'(rx_valid), 32'(4'b1110));
      ack(4'b0001); // R9: repeat ack while valid low
      chk("R9 repeat ack ignored", 32'(rx_valid), 32'(4'b1110));
      ack(4'b1100);
      chk("R4 rx2 rx3 dropped", 32'(rx_valid), 32'(4'b0010));
      chk("R5 not retired early", 32'(rx_data), 32'h A1);
      ack(4'b0011); // R9: rx0 ack out of turn, rx1 completes
      chk("R5 retired to empty", 32'(rx_valid), 32'(0));
   endtask

   task automatic t_back_to_back;
      push(8'hB2);
      push(8'hC3);
      chk("R8 first head", 32'(rx_data), 32'h B2);
      ack(ALL);
      chk("R6 next head all valid", 32'(rx_valid), 32'(ALL));
      chk("R6 next head data", 32'(rx_data), 32'h C3);
      ack(4'b1010);
      ack(4'b0101);
      chk("R5 drained", 32'(rx_valid), 32'(0));
   endtask

   task automatic t_full;
      for (int k = 0; k < DEPTH; k++) begin
         chk("R7 not full yet", 32'(in_full), 32'(0));
         push(8'(8'h10 + k));
      end
      chk("R7 full", 32'(in_full), 32'(1));
      push(8'hEE); // R7: must be dropped
      chk("R7 still full", 32'(in_full), 32'(1));
      for (int k = 0; k < DEPTH; k++) begin
         chk("R8 order valid", 32'(rx_valid), 32'(ALL));
         chk("R8 order data", 32'(rx_data), 32'(8'(8'h10 + k)));
         ack(ALL);
      end
      chk("R7 extra dropped", 32'(rx_valid), 32'(0));
      chk("R7 not full after drain", 32'(in_full), 32'(0));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      t_reset();
      t_staggered();
      t_back_to_back();
      t_full();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule